// File: doc/BRIEF.md
# Odd-Multiple Lookup Constant Multiplier

This block multiplies an unsigned L-bit operand by a coefficient fixed at elaboration time. It uses no multiplier array. A small table holds only the odd multiples of the coefficient. Every other product comes from shifting one of those entries to the left. The table is filled from the coefficient parameter when the design is elaborated, so it needs no loading port.

The operand is split into an odd part and a power of two. The power of two is set by the number of trailing zero bits in the operand. The odd part selects a table word, and the trailing-zero count drives a logarithmic barrel shifter. An all-zero operand has no odd part. A dedicated zero detector therefore forces the result to zero, overriding whatever word the table would have supplied.

The product is registered, and a valid flag travels with it. Typical users are memory-based filter taps that multiply by a constant.

Top module: `odd_lut_mult`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0 and out_prod is 0.
- R2: out_valid in a cycle equals in_valid in the previous clock cycle, so there is one cycle of latency.
- R3: For every operand X presented with in_valid high, out_prod one cycle later equals A*X. The product is (W+L) bits wide and is never truncated.
- R4: For an odd X (bit 0 = 1), the product is the table entry with index (X-1)/2, which holds (X)*A, with no shift applied.
- R5: For an even nonzero X, the product is the odd multiple of A for the odd part of X, shifted left by the number of trailing zeros of X (for example X = 8 yields A shifted left by 3).
- R6: X = 0 yields a product of 0 even when the previous product was nonzero, although the decoded table index is 0, which holds 1*A.
- R7: When in_valid is low, out_prod holds its previous value.
- R8: The table has 2^(L-1) entries of W+L bits each, and the largest operand (all ones) gives the full-width product without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand valid |
| in_x | input | L | Unsigned operand |
| out_valid | output | 1 | Product valid, one cycle after in_valid |
| out_prod | output | W+L | Registered product A*X |

## Verification
The zero override and the table read happen in the same cycle. An all-zero operand still decodes to table index 0 with a shift of 0, so the path carries 1*A while the zero detector must win. This case is provoked by presenting X = 0 directly after a nonzero operand and after an odd operand. The check passes only if the registered product is exactly zero, not A and not the previous value. The shift path and the zero override also meet on operands with many trailing zeros, such as X = 8 followed by X = 0. In that pattern the largest shift is applied one cycle and suppressed the next.

// File: rtl/odd_lut_mult.sv
module odd_lut_mult #(
  parameter int L = 4,
  parameter int W = 8,
  parameter logic [W-1:0] A = 8'd219
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [L-1:0]   in_x,
  output logic           out_valid,
  output logic [W+L-1:0] out_prod
);
  localparam int P    = W + L;
  localparam int AW   = L - 1;
  localparam int NODD = 2 ** AW;
  localparam int SW   = (L > 1) ? $clog2(L) : 1;

  logic [P-1:0]  lut [NODD];
  logic [SW-1:0] tz;
  logic [AW-1:0] addr;
  logic [P-1:0]  stg [SW+1];
  logic          x_zero;
  logic [P-1:0]  nxt;

  for (genvar i = 0; i < NODD; i++) begin : g_lut
    assign lut[i] = P'(A) * P'(2 * i + 1);
  end

  always_comb begin
    tz = '0;
    for (int i = L - 1; i >= 0; i--) begin
      if (in_x[i]) tz = SW'(i);
    end
  end

  assign addr   = AW'((in_x >> tz) >> 1);
  assign stg[0] = lut[addr];

  for (genvar k = 0; k < SW; k++) begin : g_shift
    assign stg[k+1] = tz[k] ? (stg[k] << (2 ** k)) : stg[k];
  end

  assign x_zero = ~|in_x;
  assign nxt    = x_zero ? '0 : stg[SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_prod <= nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_prod == P'(A) * P'($past(in_x))); // R3
  AST_ODD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_x[0]) |=> out_prod == lut[$past(addr)]); // R4
  AST_ZERO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_x == '0) |=> out_prod == '0); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_prod)); // R7
endmodule

// File: tb/odd_lut_mult_test.sv
module odd_lut_mult_test;
  localparam int L = 4;
  localparam int W = 8;
  localparam int P = W + L;
  localparam logic [W-1:0] CA = 8'd219;
  localparam logic [P-1:0] VEC [16] = '{
    12'd0,    12'd219,  12'd438,  12'd657,
    12'd876,  12'd1095, 12'd1314, 12'd1533,
    12'd1752, 12'd1971, 12'd2190, 12'd2409,
    12'd2628, 12'd2847, 12'd3066, 12'd3285};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [L-1:0] in_x = '0;
  logic out_valid;
  logic [P-1:0] out_prod;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  odd_lut_mult #(.L(L), .W(W), .A(CA)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_prod(out_prod));

  task automatic chk(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic [L-1:0] x);
    in_valid = v;
    in_x = x;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    total++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    in_x = 4'd15;
    @(negedge clk);
    chk("R1 valid in reset", P'(out_valid), '0);
    chk("R1 product in reset", out_prod, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", P'(out_valid), '0);
    chk("R1 product after reset", out_prod, '0);

    for (int i = 0; i < 16; i++) begin
      put(1'b1, 4'(i));
      chk("R2 valid", P'(out_valid), 1);
      if (i == 0) chk("R6 zero sweep", out_prod, VEC[i]);
      else if (i % 2 == 1) chk("R4 odd sweep", out_prod, VEC[i]);
      else chk("R5 even sweep", out_prod, VEC[i]);
      chk("R3 sweep", out_prod, P'(CA) * P'(i));
    end

    put(1'b1, 4'd15);
    chk("R8 max operand", out_prod, 12'd3285);
    put(1'b1, 4'd0);
    chk("R6 zero after max", out_prod, '0);
    put(1'b1, 4'd1);
    chk("R4 unit", out_prod, 12'd219);
    put(1'b1, 4'd0);
    chk("R6 zero after odd", out_prod, '0);
    put(1'b1, 4'd8);
    chk("R5 shift by three", out_prod, 12'd219 << 3);
    put(1'b1, 4'd0);
    chk("R6 zero after max shift", out_prod, '0);
    put(1'b1, 4'd12);
    chk("R5 shift by two", out_prod, 12'd657 << 2);
    put(1'b0, 4'd7);
    chk("R2 valid low", P'(out_valid), '0);
    chk("R7 hold", out_prod, 12'd2628);
    put(1'b0, 4'd0);
    chk("R7 hold zero operand", out_prod, 12'd2628);
    put(1'b1, 4'd6);
    chk("R2 valid again", P'(out_valid), 1);
    chk("R5 shift by one", out_prod, 12'd657 << 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule